// File: doc/BRIEF.md
# Consecutive-Result Threshold Watcher

This block observes the stream of conversion results leaving an analog-to-digital converter and raises a sticky flag once a chosen channel has produced a programmed number of results in a row that meet a threshold condition. Each result arrives as a one-cycle valid strobe with a 3-bit channel number and a 12-bit unsigned value. A single configuration word sets the watched channel, the condition, the 12-bit threshold, the required run length and an enable bit.

The condition is either "result below threshold" or "result at or above threshold". The run length runs from 1 to 16 and is held in a 4-bit field as length minus one. A system normally places two instances side by side, each with its own configuration, to watch two limits at once. Software clears the flag with a one-cycle clear pulse (the write-one-to-clear decoded outside the block). The interrupt request is the flag gated by an interrupt-enable input.

Top module: `adc_match_watch`

## Requirements
- R1: After reset the flag and the interrupt request are 0 and the configuration word is all zeros, so the watcher is disabled.
- R2: With the enable bit set, the flag goes to 1 in the cycle after the N-th consecutive matching result from the watched channel, where N is the run-length field (bits 8:5) plus one, covering 1 to 16; before that result it stays 0.
- R3: With the condition bit (bit 1) at 0, a result matches only when it is strictly below the threshold (bits 20:9); a result equal to the threshold does not match.
- R4: With the condition bit at 1, a result matches when it is equal to or above the threshold.
- R5: A result from the watched channel (bits 4:2) that does not match restarts the run from zero.
- R6: Results carrying any other channel number leave the run count unchanged.
- R7: The flag stays at 1 until a clear pulse; a clear pulse in the same cycle as a run completing leaves the flag at 1.
- R8: When a run completes the count restarts, so a further full run of N matches is needed to set the flag again after it is cleared.
- R9: Any configuration write restarts the run count; with the enable bit (bit 0) at 0, including after writing zero, results have no effect.
- R10: The interrupt request equals the flag while the interrupt-enable input is 1 and is 0 otherwise.
- R11: Comparison treats results and threshold as unsigned 12-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 21 | Configuration word: enable, condition, channel, run length minus one, threshold |
| flag_clr | input | 1 | One-cycle flag clear pulse |
| irq_en | input | 1 | Interrupt enable |
| res_vld | input | 1 | Conversion result valid strobe |
| res_ch | input | 3 | Channel of the result |
| res_data | input | 12 | Unsigned result value |
| flag | output | 1 | Sticky run-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The run count is hidden, so a wrong count only shows as a flag that rises one or more results early or late; every check therefore sends exact result sequences and samples the flag one cycle after each result. A count that fails to restart on a miss, a foreign channel, a configuration write or a completed run shows at the latest after one full run of the affected length, which the bench lengths keep to 16 results or fewer.

// File: rtl/adc_match_pkg.sv
// Package: shared types for the consecutive-result threshold watcher.
// Assumes: the condition bit encodes 0 = below, 1 = at or above.
package adc_match_pkg;

    typedef enum logic {
        COND_BELOW    = 1'b0,
        COND_AT_ABOVE = 1'b1
    } cond_e;

endpackage

// File: rtl/amw_cfg_reg.sv
// Module: amw_cfg_reg
// Holds the configuration word and splits it into fields.
// Assumes: layout from bit 0 upward is enable, condition, channel,
// run length minus one, threshold.
module amw_cfg_reg
    import adc_match_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 4,
    localparam int CFG_W = 2 + CH_W + CNT_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CFG_W-1:0]  wdata,
    output logic              en,
    output cond_e             cond,
    output logic [CH_W-1:0]   sel_ch,
    output logic [CNT_W-1:0]  run_m1,
    output logic [DATA_W-1:0] thr
);
    localparam int CH_LO  = 2;
    localparam int CNT_LO = CH_LO + CH_W;
    localparam int THR_LO = CNT_LO + CNT_W;

    logic [CFG_W-1:0] word;

    // Purpose: capture the configuration word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (wr)
            word <= wdata;
    end

    // Purpose: slice the stored word into its fields.
    always_comb begin
        en     = word[0];
        cond   = cond_e'(word[1]);
        sel_ch = word[CH_LO  +: CH_W];
        run_m1 = word[CNT_LO +: CNT_W];
        thr    = word[THR_LO +: DATA_W];
    end
endmodule

// File: rtl/amw_cond.sv
// Module: amw_cond
// Decides whether one result meets the selected threshold condition.
// Assumes: result and threshold are unsigned straight binary.
module amw_cond
    import adc_match_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] thr,
    input  cond_e             cond,
    output logic              match
);
    logic below;

    // Purpose: unsigned compare and condition select.
    always_comb begin
        below = (data < thr);
        match = (cond == COND_BELOW) ? below : !below;
    end
endmodule

// File: rtl/amw_run_counter.sv
// Module: amw_run_counter
// Counts consecutive matching results on the watched channel and sets a
// sticky flag when the run reaches run_m1 + 1.
// Assumes: hit is a one-cycle strobe already qualified by channel and
// enable; restart has priority over a hit in the same cycle.
module amw_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             match,
    input  logic [CNT_W-1:0] run_m1,
    input  logic             restart,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    logic             done;

    // Purpose: detect the result that completes the run.
    always_comb done = hit && match && (cnt == run_m1) && !restart;

    // Purpose: advance, restart or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (hit) begin
            if (!match || cnt == run_m1)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // Purpose: sticky flag, setting wins over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (done)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R2: count never passes the programmed run length minus one
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= run_m1);

    // R5: a failing result on the watched channel empties the run
    a_r5_miss_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !match && !restart) |=> (cnt == '0));

    // R6: without a hit or restart the count holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !restart) |=> $stable(cnt));

    // R7: flag persists until a clear pulse
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8: a completed run sets the flag and empties the count
    a_r8_done_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flag && cnt == '0));

    // R9: restart empties the count
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/adc_match_watch.sv
// Module: adc_match_watch (top)
// Watches conversion results of one channel and flags a programmed run of
// consecutive results meeting a threshold condition.
// Assumes: results arrive as one-cycle strobes; flag_clr is a decoded
// write-one-to-clear pulse.
module adc_match_watch
    import adc_match_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 4,
    localparam int CFG_W = 2 + CH_W + CNT_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              res_vld,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [DATA_W-1:0] res_data,
    output logic              flag,
    output logic              irq
);
    logic              en;
    cond_e             cond;
    logic [CH_W-1:0]   sel_ch;
    logic [CNT_W-1:0]  run_m1;
    logic [DATA_W-1:0] thr;
    logic              match;
    logic              hit;
    logic              restart;

    amw_cfg_reg #(.CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .en(en), .cond(cond), .sel_ch(sel_ch), .run_m1(run_m1), .thr(thr)
    );

    amw_cond #(.DATA_W(DATA_W)) u_cond (
        .data(res_data), .thr(thr), .cond(cond), .match(match)
    );

    // Purpose: qualify results and form the restart request.
    always_comb begin
        hit     = res_vld && en && (res_ch == sel_ch);
        restart = cfg_wr || !en;
    end

    amw_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk(clk), .rst_n(rst_n), .hit(hit), .match(match), .run_m1(run_m1),
        .restart(restart), .clr(flag_clr), .flag(flag)
    );

    // Purpose: gate the flag onto the interrupt request.
    always_comb irq = flag && irq_en;

    // R9: while disabled, a flag that is low stays low
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flag) |=> !flag);
endmodule

// File: tb/adc_match_watch_test.sv
module adc_match_watch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [20:0] cfg_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        res_vld = 1'b0;
    logic [2:0]  res_ch = '0;
    logic [11:0] res_data = '0;
    logic        flag;
    logic        irq;

    int total = 0;
    int bad = 0;

    adc_match_watch uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .flag_clr(flag_clr), .irq_en(irq_en), .res_vld(res_vld),
        .res_ch(res_ch), .res_data(res_data), .flag(flag), .irq(irq)
    );

    always #4 clk = ~clk;

    // table entry: {vld, clr, ch[2:0], data[11:0], expected flag}
    localparam int NV = 13;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 3'd5, 12'h900, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h800, 1'b0},
        {1'b1, 1'b0, 3'd3, 12'h000, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'hFFF, 1'b1},
        {1'b0, 1'b1, 3'd0, 12'h000, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h7FF, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h800, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h7FF, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h800, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'h801, 1'b0},
        {1'b1, 1'b0, 3'd5, 12'hA00, 1'b1},
        {1'b1, 1'b0, 3'd5, 12'h100, 1'b1},
        {1'b0, 1'b1, 3'd0, 12'h000, 1'b0}
    };

    function automatic logic [20:0] mk_cfg(input logic en, input logic ge,
                                           input logic [2:0] ch, input int n,
                                           input logic [11:0] thr);
        logic [3:0] m1;
        m1 = 4'(n - 1);
        return {thr, m1, ch, ge, en};
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [20:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // drives one cycle of stimulus; flag is valid at the following negedge
    task automatic step(input logic vld, input logic clr, input logic [2:0] ch,
                        input logic [11:0] d);
        res_vld = vld; flag_clr = clr; res_ch = ch; res_data = d;
        @(negedge clk);
        res_vld = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic clear_flag();
        step(1'b0, 1'b1, 3'd0, 12'h000);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        irq_en = 1'b1;
        check(flag, 1'b0, "R1 flag after reset");
        check(irq, 1'b0, "R1 irq after reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: disabled after reset, a result that would match nothing sets nothing
        step(1'b1, 1'b0, 3'd0, 12'h000);
        check(flag, 1'b0, "R1 disabled after reset");

        // table walk: channel 5, at-or-above 0x800, run of 3
        write_cfg(mk_cfg(1'b1, 1'b1, 3'd5, 3, 12'h800));
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15:13], VEC[i][12:1]);
            check(flag, VEC[i][0], $sformatf("R2/R4/R5/R6/R7/R11 vector %0d", i));
        end

        // R3: below condition, equal is not a match
        write_cfg(mk_cfg(1'b1, 1'b0, 3'd0, 1, 12'h010));
        step(1'b1, 1'b0, 3'd0, 12'h010);
        check(flag, 1'b0, "R3 equal is no match");
        step(1'b1, 1'b0, 3'd0, 12'h00F);
        check(flag, 1'b1, "R3 below matches");
        check(irq, 1'b1, "R10 irq follows flag");
        irq_en = 1'b0;
        #1;
        check(irq, 1'b0, "R10 irq masked");
        irq_en = 1'b1;

        // R7: clear and completion in the same cycle keep the flag
        step(1'b1, 1'b1, 3'd0, 12'h000);
        check(flag, 1'b1, "R7 set wins over clear");
        clear_flag();
        check(flag, 1'b0, "R7 clear pulse");

        // R8: count restarts after a completed run
        write_cfg(mk_cfg(1'b1, 1'b1, 3'd2, 2, 12'h800));
        step(1'b1, 1'b0, 3'd2, 12'h800);
        step(1'b1, 1'b0, 3'd2, 12'h800);
        check(flag, 1'b1, "R8 first run");
        step(1'b1, 1'b0, 3'd2, 12'h800);
        clear_flag();
        check(flag, 1'b0, "R8 one match after run does not set");
        step(1'b1, 1'b0, 3'd2, 12'h800);
        check(flag, 1'b1, "R8 second run complete");
        clear_flag();

        // R9: configuration write restarts the count
        step(1'b1, 1'b0, 3'd2, 12'h800);
        write_cfg(mk_cfg(1'b1, 1'b1, 3'd2, 2, 12'h800));
        step(1'b1, 1'b0, 3'd2, 12'h800);
        check(flag, 1'b0, "R9 write restarts count");
        step(1'b1, 1'b0, 3'd2, 12'h800);
        check(flag, 1'b1, "R9 full run after write");
        clear_flag();

        // R9: enable bit low makes results ineffective
        write_cfg(mk_cfg(1'b0, 1'b1, 3'd0, 1, 12'h000));
        step(1'b1, 1'b0, 3'd0, 12'h123);
        check(flag, 1'b0, "R9 disabled ignores results");
        write_cfg(21'd0);
        step(1'b1, 1'b0, 3'd0, 12'h000);
        check(flag, 1'b0, "R9 zero config disables");

        // R2: longest run of 16
        write_cfg(mk_cfg(1'b1, 1'b1, 3'd7, 16, 12'h000));
        for (int k = 0; k < 15; k++) step(1'b1, 1'b0, 3'd7, 12'(k));
        check(flag, 1'b0, "R2 15 of 16");
        step(1'b1, 1'b0, 3'd7, 12'hFFF);
        check(flag, 1'b1, "R2 16 of 16");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule